// File: doc/BRIEF.md
# External Bus Hold Handshake Controller

This block lends the external memory bus to an outside master. The outside master asks for the bus by pulling an active-low hold request. The controller passes that request through a synchronizer and stops the memory controller from starting new work. It lets any transaction already in flight run to completion. It then releases every bus output to high impedance and, one window later, pulls its active-low acknowledge. When the request is withdrawn, the controller drives the bus again after a fixed, bounded delay and only then removes the acknowledge.

All windows are counted in clock cycles and set by parameters. The defaults are as follows:

- The bus goes to high impedance no sooner than 4 cycles after the request is first sampled.
- The acknowledge follows the bus release by 1 cycle.
- The bus is driven again 4 cycles after the withdrawal is first sampled. The permitted range for this delay is 3 to 7 cycles.
- The acknowledge rises 1 cycle after the bus is driven again.

When the burst-length option is set, a burst that is running may go on until it has completed at least 8 beats before new work is blocked. A disable bit refuses the hold for as long as it is set.

Top module: `bus_hold_ctrl`

## Requirements
- R1: During and after reset, `hold_ack_n` is 1 (not granted), `bus_oe` is 1 (bus driven) and `txn_inhibit` is 0.
- R2: With the memory idle, `bus_oe` falls exactly HIZ_MIN (4) clock edges after the first edge that samples `hold_req_n` low, and never earlier.
- R3: `hold_ack_n` falls exactly ACK_LAG (1) edge after `bus_oe` falls, and it only falls while `bus_oe` is already 0.
- R4: `bus_oe` returns to 1 exactly REDRIVE_DLY (4) edges after the first edge that samples `hold_req_n` high. This delay always lies within 3 to 7 edges.
- R5: `hold_ack_n` rises exactly ACK_LAG (1) edge after `bus_oe` rises, and only while `bus_oe` is 1.
- R6: `bus_oe` never falls at an edge where `mem_busy` is sampled 1. When a busy period outlasts the minimum window, the bus is released at the first edge that samples `mem_busy` low.
- R7: With `burst_mode` = 1, `txn_inhibit` stays 0 while draining as long as `mem_busy` = 1 and fewer than BURST_MIN (8) `beat_done` pulses have been sampled in the current busy run. It rises one edge after the edge that samples the 8th pulse.
- R8: While `hold_disable` = 1, a request never leads to a grant and `hold_ack_n` stays 1. Setting the bit during a drain abandons the drain. Clearing it while the request is still low lets the grant proceed.
- R9: A request withdrawn before the bus is released leaves `hold_ack_n` at 1 and returns `txn_inhibit` to 0.
- R10: `txn_inhibit` is 1 from the edge that starts a drain, subject to the R7 exception, until the edge at which `hold_ack_n` returns to 1. It is 1 whenever `hold_ack_n` is 0.
- R11: Once granted, `hold_ack_n` stays 0 for as long as the synchronized request stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| hold_req_n | input | 1 | Asynchronous hold request from the outside master, active low |
| mem_busy | input | 1 | Memory controller has a transaction in flight |
| beat_done | input | 1 | One-cycle pulse per completed burst access |
| burst_mode | input | 1 | 1 lets a running burst complete BURST_MIN beats before new work is blocked |
| hold_disable | input | 1 | 1 refuses every hold request |
| hold_ack_n | output | 1 | Hold acknowledge, active low; 0 means the outside master owns the bus |
| bus_oe | output | 1 | Bus output enable; 0 puts all bus outputs in high impedance |
| txn_inhibit | output | 1 | 1 tells the memory controller to start no new transaction |

## Verification
The embedded assertions check the following on every cycle:

- The release happens only at an edge where the memory is idle.
- The ordering of acknowledge against output enable holds in both directions.
- The disable bit and a withdrawn request each keep the acknowledge high.
- The grant persists while the request is held.
- The inhibit is present whenever the bus is granted.
- The burst-run counter stays within its bound.

The exact window lengths are shown only by the bench scenarios. These are the 4-edge release, the 1-edge acknowledge lag, the 4-edge redrive, the stretched drain behind a long busy period, and the point where the burst allowance ends. The bench checks them by edge-to-edge measurement and by a cycle-level reference model.

// File: rtl/bus_hold_pkg.sv
package bus_hold_pkg;
  typedef enum logic [2:0] {
    ST_OWN     = 3'd0,
    ST_DRAIN   = 3'd1,
    ST_HIZ     = 3'd2,
    ST_GRANT   = 3'd3,
    ST_REDRIVE = 3'd4,
    ST_RELEASE = 3'd5
  } hold_state_e;
endpackage

// File: rtl/bus_hold_sync.sv
module bus_hold_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) shreg <= {STAGES{RESET_VAL}};
    else     shreg <= {shreg[STAGES-2:0], d};
  end

  assign q = shreg[STAGES-1];
endmodule

// File: rtl/bus_hold_burst.sv
module bus_hold_burst #(
  parameter int BURST_MIN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic mem_busy,
  input  logic beat_done,
  output logic run_short
);
  localparam int RUN_W = $clog2(BURST_MIN + 1);
  localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(BURST_MIN);

  logic [RUN_W-1:0] run_cnt;

  // beats completed in the current uninterrupted busy run, saturating
  always_ff @(posedge clk) begin
    if (rst || !mem_busy)                      run_cnt <= '0;
    else if (beat_done && run_cnt != RUN_FULL) run_cnt <= run_cnt + 1'b1;
  end

  assign run_short = mem_busy && (run_cnt != RUN_FULL);

  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (rst)
    run_cnt <= RUN_FULL);                                      // R7
  AST_RUN_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !mem_busy |=> (run_cnt == '0));                            // R7
endmodule

// File: rtl/bus_hold_fsm.sv
module bus_hold_fsm
  import bus_hold_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HIZ_MIN     = 4,
  parameter int ACK_LAG     = 1,
  parameter int REDRIVE_DLY = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic mem_busy,
  input  logic run_short,
  input  logic burst_mode,
  input  logic hold_disable,
  output logic bus_oe,
  output logic ack_n,
  output logic inhibit
);
  localparam int DRAIN_MIN = HIZ_MIN - SYNC_STAGES;
  localparam int RD_WAIT   = REDRIVE_DLY - SYNC_STAGES;
  localparam int MAX_A     = (DRAIN_MIN > ACK_LAG) ? DRAIN_MIN : ACK_LAG;
  localparam int CNT_MAX   = (MAX_A > RD_WAIT) ? MAX_A : RD_WAIT;
  localparam int CNT_W     = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] DRAIN_LAST = CNT_W'(DRAIN_MIN - 1);
  localparam logic [CNT_W-1:0] LAG_LAST   = CNT_W'(ACK_LAG - 1);
  localparam logic [CNT_W-1:0] RD_LAST    = CNT_W'(RD_WAIT - 1);

  hold_state_e      state, nstate;
  logic [CNT_W-1:0] cnt, cnt_n;

  always_comb begin
    nstate = state;
    cnt_n  = cnt;
    unique case (state)
      ST_OWN: begin
        if (req && !hold_disable) begin
          nstate = ST_DRAIN;
          cnt_n  = '0;
        end
      end
      ST_DRAIN: begin
        if (!req || hold_disable) begin
          nstate = ST_OWN;
          cnt_n  = '0;
        end else if (cnt == DRAIN_LAST && !mem_busy) begin
          nstate = ST_HIZ;
          cnt_n  = '0;
        end else if (cnt != DRAIN_LAST) begin
          cnt_n = cnt + 1'b1;
        end
      end
      ST_HIZ: begin
        if (cnt == LAG_LAST) begin
          nstate = ST_GRANT;
          cnt_n  = '0;
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end
      ST_GRANT: begin
        if (!req) begin
          nstate = ST_REDRIVE;
          cnt_n  = '0;
        end
      end
      ST_REDRIVE: begin
        if (cnt == RD_LAST) begin
          nstate = ST_RELEASE;
          cnt_n  = '0;
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end
      ST_RELEASE: begin
        if (cnt == LAG_LAST) begin
          nstate = ST_OWN;
          cnt_n  = '0;
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end
      default: begin
        nstate = ST_OWN;
        cnt_n  = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_OWN;
      cnt     <= '0;
      bus_oe  <= 1'b1;
      ack_n   <= 1'b1;
      inhibit <= 1'b0;
    end else begin
      state   <= nstate;
      cnt     <= cnt_n;
      bus_oe  <= !(nstate inside {ST_HIZ, ST_GRANT, ST_REDRIVE});
      ack_n   <= !(nstate inside {ST_GRANT, ST_REDRIVE, ST_RELEASE});
      inhibit <= (nstate != ST_OWN) &&
                 !(nstate == ST_DRAIN && burst_mode && run_short);
    end
  end

  AST_HIZ_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_oe) |-> !$past(mem_busy));                       // R6
  AST_ACK_AFTER_HIZ: assert property (@(posedge clk) disable iff (rst)
    $fell(ack_n) |-> !bus_oe);                                 // R3
  AST_DRIVE_BEFORE_UNACK: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_n) |-> bus_oe);                                  // R5
  AST_DISABLE_REFUSES: assert property (@(posedge clk) disable iff (rst)
    (hold_disable && bus_oe && ack_n) |=> ack_n);              // R8
  AST_WITHDRAW_NO_ACK: assert property (@(posedge clk) disable iff (rst)
    (!req && bus_oe && ack_n) |=> ack_n);                      // R9
  AST_INHIBIT_WHEN_ACK: assert property (@(posedge clk) disable iff (rst)
    !ack_n |-> inhibit);                                       // R10
  AST_GRANT_PERSISTS: assert property (@(posedge clk) disable iff (rst)
    (!ack_n && !bus_oe && req) |=> !ack_n);                    // R11
endmodule

// File: rtl/bus_hold_ctrl.sv
module bus_hold_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int HIZ_MIN     = 4,
  parameter int ACK_LAG     = 1,
  parameter int REDRIVE_DLY = 4,
  parameter int BURST_MIN   = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_req_n,
  input  logic mem_busy,
  input  logic beat_done,
  input  logic burst_mode,
  input  logic hold_disable,
  output logic hold_ack_n,
  output logic bus_oe,
  output logic txn_inhibit
);
  logic req_sync_n;
  logic run_short;

  bus_hold_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (hold_req_n),
    .q   (req_sync_n)
  );

  bus_hold_burst #(.BURST_MIN(BURST_MIN)) u_burst (
    .clk       (clk),
    .rst       (rst),
    .mem_busy  (mem_busy),
    .beat_done (beat_done),
    .run_short (run_short)
  );

  bus_hold_fsm #(
    .SYNC_STAGES (SYNC_STAGES),
    .HIZ_MIN     (HIZ_MIN),
    .ACK_LAG     (ACK_LAG),
    .REDRIVE_DLY (REDRIVE_DLY)
  ) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .req          (!req_sync_n),
    .mem_busy     (mem_busy),
    .run_short    (run_short),
    .burst_mode   (burst_mode),
    .hold_disable (hold_disable),
    .bus_oe       (bus_oe),
    .ack_n        (hold_ack_n),
    .inhibit      (txn_inhibit)
  );
endmodule

// File: tb/bus_hold_ctrl_bench.sv
module bus_hold_ctrl_bench;
  localparam int SYNC  = 2;
  localparam int HIZ   = 4;
  localparam int LAG   = 1;
  localparam int RDLY  = 4;
  localparam int BURST = 8;
  localparam int WD_LIMIT = 5000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hold_req_n = 1'b1, mem_busy = 1'b0, beat_done = 1'b0;
  logic burst_mode = 1'b0, hold_disable = 1'b0;
  logic hold_ack_n, bus_oe, txn_inhibit;

  int cyc = 0, checks = 0, errs = 0;
  bit saw_ack_low = 1'b0;
  bit saw_oe_low = 1'b0;

  always #10 clk = ~clk;

  bus_hold_ctrl #(.SYNC_STAGES(SYNC), .HIZ_MIN(HIZ), .ACK_LAG(LAG),
                  .REDRIVE_DLY(RDLY), .BURST_MIN(BURST)) u_bus_hold_ctrl (
    .clk(clk), .rst(rst), .hold_req_n(hold_req_n), .mem_busy(mem_busy),
    .beat_done(beat_done), .burst_mode(burst_mode), .hold_disable(hold_disable),
    .hold_ack_n(hold_ack_n), .bus_oe(bus_oe), .txn_inhibit(txn_inhibit)
  );

  task automatic check_eq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference model: a delay queue for the synchronizer,
  // integer phase and timer for the handshake windows
  bit mq[$];
  int mph = 0, mt = 0, mrun = 0;
  bit m_ack_n = 1'b1, m_oe = 1'b1, m_inh = 1'b0;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      mq.delete();
      for (int i = 0; i < SYNC; i++) mq.push_back(1'b1);
      mph = 0; mt = 0; mrun = 0;
      m_ack_n = 1'b1; m_oe = 1'b1; m_inh = 1'b0;
    end else begin
      bit req, short_run;
      int nph;
      req = !mq[0];
      void'(mq.pop_front());
      mq.push_back(hold_req_n);
      short_run = mem_busy && (mrun < BURST);
      if (!mem_busy) mrun = 0;
      else if (beat_done && mrun < BURST) mrun++;
      nph = mph;
      case (mph)
        0: if (req && !hold_disable) begin nph = 1; mt = 0; end
        1: if (!req || hold_disable) begin nph = 0; mt = 0; end
           else if (mt >= HIZ - SYNC - 1 && !mem_busy) begin nph = 2; mt = 0; end
           else mt++;
        2: if (mt >= LAG - 1) begin nph = 3; mt = 0; end else mt++;
        3: if (!req) begin nph = 4; mt = 0; end
        4: if (mt >= RDLY - SYNC - 1) begin nph = 5; mt = 0; end else mt++;
        5: if (mt >= LAG - 1) begin nph = 0; mt = 0; end else mt++;
        default: nph = 0;
      endcase
      mph = nph;
      m_oe    = !(nph >= 2 && nph <= 4);
      m_ack_n = !(nph >= 3);
      m_inh   = (nph != 0) && !(nph == 1 && burst_mode && short_run);
    end
    if (cyc >= WD_LIMIT) begin
      checks++; errs++;
      $display("FAIL R1 watchdog: actual cycles=%0d expected < %0d", cyc, WD_LIMIT);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      check_eq("R3 ack vs model", hold_ack_n, m_ack_n);
      check_eq("R2 oe vs model", bus_oe, m_oe);
      check_eq("R10 inhibit vs model", txn_inhibit, m_inh);
      if (!hold_ack_n) saw_ack_low = 1'b1;
      if (!bus_oe) saw_oe_low = 1'b1;
    end
  end

  task automatic wait_for(ref logic sig, input logic val, output int at);
    int guard = 0;
    while (sig !== val && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    at = cyc;
  endtask

  // request, hold for `held` cycles after ack, release; checks the windows
  task automatic full_cycle(int held, int exp_fall_lat);
    int t0, tf, ta, r0, tr, tu;
    @(negedge clk);
    hold_req_n = 1'b0;
    t0 = cyc + 1;
    wait_for(bus_oe, 1'b0, tf);
    check_eq("R2 request to high-impedance edges", tf - t0, exp_fall_lat);
    wait_for(hold_ack_n, 1'b0, ta);
    check_eq("R3 high-impedance to ack edges", ta - tf, LAG);
    repeat (held) @(negedge clk);
    check_eq("R11 ack held while requested", hold_ack_n, 0);
    hold_req_n = 1'b1;
    r0 = cyc + 1;
    wait_for(bus_oe, 1'b1, tr);
    check_eq("R4 withdraw to redrive edges", tr - r0, RDLY);
    check_eq("R4 redrive within 3..7", int'((tr - r0) >= 3 && (tr - r0) <= 7), 1);
    wait_for(hold_ack_n, 1'b1, tu);
    check_eq("R5 redrive to ack release edges", tu - tr, LAG);
    @(negedge clk);
    check_eq("R10 inhibit cleared after release", txn_inhibit, 0);
  endtask

  initial begin
    int tb0, tf;
    repeat (3) @(negedge clk);
    check_eq("R1 reset ack", hold_ack_n, 1);
    check_eq("R1 reset oe", bus_oe, 1);
    check_eq("R1 reset inhibit", txn_inhibit, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // idle bus: minimum delays (R2..R5)
    full_cycle(6, HIZ);
    repeat (4) @(negedge clk);
    full_cycle(1, HIZ);
    repeat (4) @(negedge clk);

    // long busy period stretches the drain (R6)
    mem_busy = 1'b1;
    hold_req_n = 1'b0;
    repeat (12) @(negedge clk);
    check_eq("R6 bus driven while busy", bus_oe, 1);
    check_eq("R10 inhibit during drain", txn_inhibit, 1);
    mem_busy = 1'b0;
    tb0 = cyc + 1;
    wait_for(bus_oe, 1'b0, tf);
    check_eq("R6 release at first idle edge", tf - tb0, 0);
    repeat (3) @(negedge clk);
    hold_req_n = 1'b1;
    wait_for(hold_ack_n, 1'b1, tf);
    repeat (4) @(negedge clk);

    // burst allowance (R7)
    burst_mode = 1'b1;
    mem_busy = 1'b1;
    beat_done = 1'b1;
    hold_req_n = 1'b0;
    repeat (6) @(negedge clk);
    check_eq("R7 inhibit low inside short burst", txn_inhibit, 0);
    repeat (4) @(negedge clk);
    check_eq("R7 inhibit high after 8 beats", txn_inhibit, 1);
    check_eq("R6 bus still driven during burst", bus_oe, 1);
    beat_done = 1'b0;
    mem_busy = 1'b0;
    wait_for(hold_ack_n, 1'b0, tf);
    check_eq("R3 ack after burst drain", hold_ack_n, 0);
    hold_req_n = 1'b1;
    wait_for(hold_ack_n, 1'b1, tf);
    burst_mode = 1'b0;
    repeat (4) @(negedge clk);

    // disable refuses the hold (R8)
    hold_disable = 1'b1;
    saw_ack_low = 1'b0;
    saw_oe_low = 1'b0;
    hold_req_n = 1'b0;
    repeat (20) @(negedge clk);
    check_eq("R8 no ack while disabled", int'(saw_ack_low), 0);
    check_eq("R8 bus driven while disabled", int'(saw_oe_low), 0);
    check_eq("R8 no inhibit while disabled", txn_inhibit, 0);
    hold_disable = 1'b0;
    wait_for(hold_ack_n, 1'b0, tf);
    check_eq("R8 grant after disable cleared", hold_ack_n, 0);
    hold_req_n = 1'b1;
    wait_for(hold_ack_n, 1'b1, tf);
    repeat (4) @(negedge clk);

    // disable set mid-drain abandons it (R8)
    mem_busy = 1'b1;
    hold_req_n = 1'b0;
    repeat (5) @(negedge clk);
    saw_ack_low = 1'b0;
    hold_disable = 1'b1;
    mem_busy = 1'b0;
    repeat (6) @(negedge clk);
    check_eq("R8 drain abandoned", int'(saw_ack_low), 0);
    check_eq("R8 inhibit dropped on abandon", txn_inhibit, 0);
    hold_req_n = 1'b1;
    hold_disable = 1'b0;
    repeat (4) @(negedge clk);

    // withdrawal during drain (R9)
    saw_ack_low = 1'b0;
    mem_busy = 1'b1;
    hold_req_n = 1'b0;
    repeat (4) @(negedge clk);
    hold_req_n = 1'b1;
    repeat (8) @(negedge clk);
    mem_busy = 1'b0;
    repeat (4) @(negedge clk);
    check_eq("R9 no ack after early withdraw", int'(saw_ack_low), 0);
    check_eq("R9 inhibit cleared", txn_inhibit, 0);
    check_eq("R9 bus driven", bus_oe, 1);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule